// File: doc/BRIEF.md
# Fault Latch and Alert Responder

This block sits beside a two-wire bus switch and collects the faults the switch can suffer: a bus held low past its timeout, an alert raised by a device on any of the downstream channels, and a refused attempt to connect a channel. Each fault is caught in a sticky status bit, and the block pulls an active-low alert line toward the upstream master. The status word also shows the present level of every downstream alert input.

The master finds the source in one of two ways. It can broadcast the alert response address, upon which the block asks the bus interface to return this device's own address and lets go of the alert line. Or it can address the device directly, which also lets go of the alert. The master then reads the status word and, once the fault is dealt with, writes any byte to that read-only word to clear the sticky bits. Pulling the enable input low returns the whole block to its idle state.

Bus decoding lives elsewhere: the block receives single-cycle strobes for "response address read seen", "device addressed" and "status word written", plus single-cycle fault pulses. All downstream alert inputs are active low.

Top module: `fault_alert_unit`

## Requirements
- R1: After reset, and in every cycle that follows a cycle with `enable` low, `alertN` is 1, `araReplyReq` is 0, and `statusReg` reads the idle value: live bits [NUM_CH-1:0] all 1 and bits [NUM_CH+3:NUM_CH] all 0 (0x0F for four channels).
- R2: A `stuckPulse` sets sticky bit NUM_CH+1 (bit 5) and drives `alertN` low at the next clock edge.
- R3: A `connFailPulse` sets sticky bit NUM_CH+2 (bit 6) and drives `alertN` low at the next clock edge.
- R4: Status bits [NUM_CH-1:0] show `chAlertN` as sampled at the previous edge (1 = released); a high-to-low change on any channel sets sticky bit NUM_CH (bit 4) and drives `alertN` low at that same edge.
- R5: An `araSeen` strobe while `alertN` is low makes `araReplyReq` 1 for exactly one cycle after the next edge and releases `alertN` at that edge; sticky bits are not changed.
- R6: An `araSeen` strobe while `alertN` is high leaves `araReplyReq` at 0.
- R7: An `addrHit` strobe releases `alertN` at the next edge and leaves the sticky bits unchanged.
- R8: A new fault after a release drives `alertN` low again; a fault in the same cycle as a release strobe wins.
- R9: A `statWrite` strobe clears the three sticky bits and releases `alertN`; a fault arriving in the same cycle is still recorded and keeps the alert asserted.
- R10: A channel alert that stays low does not set its sticky bit again after a clear; only a fresh falling edge does.
- R11: Status bit NUM_CH+3 (bit 7) is 1 exactly when `alertN` is 0.
- R12: While `enable` is low all fault pulses and strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low forces idle state |
| stuckPulse | input | 1 | One-cycle pulse: bus stuck-low timeout expired |
| connFailPulse | input | 1 | One-cycle pulse: a channel connect attempt was refused |
| chAlertN | input | NUM_CH | Downstream alert levels, active low |
| araSeen | input | 1 | Strobe: read of the alert response address decoded |
| addrHit | input | 1 | Strobe: this device was addressed directly |
| statWrite | input | 1 | Strobe: a byte was written to the status word |
| alertN | output | 1 | Active-low alert toward the upstream master |
| statusReg | output | NUM_CH+4 | Status word: live levels, sticky faults, alert state |
| araReplyReq | output | 1 | One-cycle request to send own address as the response |

## Verification
Every result here is one register away from its cause: a pulse, strobe or channel edge presented before a rising edge shows on `alertN`, `statusReg` and `araReplyReq` just after that edge, and `araReplyReq` falls again one edge later. The bench changes inputs one time unit after a rising edge, lets exactly one edge pass, and samples one time unit after it, so each check reads the state that the previous cycle's stimulus produced. The sweep covers every combination of the three fault sources over every channel, each followed by a clear with the channel still held low.

// File: rtl/fault_alert_pkg.sv
package fault_alert_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic goIdle;        // enable low: force idle
    logic clearLatches;  // status word written
  } dpCtrl_t;
endpackage

// File: rtl/fault_alert_dp.sv
module fault_alert_dp
  import fault_alert_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic              stuckPulse,
  input  logic              connFailPulse,
  input  logic [NUM_CH-1:0] chAlertN,
  output logic [NUM_CH-1:0] chLive,
  output logic              chLatch,
  output logic              stuckLatch,
  output logic              connLatch,
  output logic              faultEvent
);
  logic [NUM_CH-1:0] chFall;
  logic              anyFall;

  // A channel falls when its last sample was high and the pin is now low
  assign chFall  = chLive & ~chAlertN;
  assign anyFall = (|chFall) & ~ctrl.goIdle;

  assign faultEvent = ~ctrl.goIdle & (stuckPulse | connFailPulse | anyFall);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chLive     <= '1;
      chLatch    <= 1'b0;
      stuckLatch <= 1'b0;
      connLatch  <= 1'b0;
    end else if (ctrl.goIdle) begin
      chLive     <= '1;
      chLatch    <= 1'b0;
      stuckLatch <= 1'b0;
      connLatch  <= 1'b0;
    end else begin
      chLive     <= chAlertN;
      // set wins over clear so no event is lost
      chLatch    <= (chLatch    & ~ctrl.clearLatches) | anyFall;
      stuckLatch <= (stuckLatch & ~ctrl.clearLatches) | stuckPulse;
      connLatch  <= (connLatch  & ~ctrl.clearLatches) | connFailPulse;
    end
  end
endmodule

// File: rtl/fault_alert_ctrl.sv
module fault_alert_ctrl
  import fault_alert_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    araSeen,
  input  logic    addrHit,
  input  logic    statWrite,
  input  logic    faultEvent,
  output dpCtrl_t ctrl,
  output logic    alertActive,
  output logic    araReplyReq
);
  logic replyNow;
  logic releaseNow;

  assign ctrl.goIdle       = ~enable;
  assign ctrl.clearLatches = enable & statWrite;

  // Only answer the response address while this unit holds the line
  assign replyNow   = enable & araSeen & alertActive;
  assign releaseNow = replyNow | addrHit | statWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alertActive <= 1'b0;
      araReplyReq <= 1'b0;
    end else if (!enable) begin
      alertActive <= 1'b0;
      araReplyReq <= 1'b0;
    end else begin
      araReplyReq <= replyNow;
      if (faultEvent)      alertActive <= 1'b1;
      else if (releaseNow) alertActive <= 1'b0;
    end
  end
endmodule

// File: rtl/fault_alert_unit.sv
module fault_alert_unit
  import fault_alert_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                stuckPulse,
  input  logic                connFailPulse,
  input  logic [NUM_CH-1:0]   chAlertN,
  input  logic                araSeen,
  input  logic                addrHit,
  input  logic                statWrite,
  output logic                alertN,
  output logic [NUM_CH+3:0]   statusReg,
  output logic                araReplyReq
);
  dpCtrl_t           ctrl;
  logic              faultEvent;
  logic              alertActive;
  logic [NUM_CH-1:0] chLive;
  logic              chLatch, stuckLatch, connLatch;

  fault_alert_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .araSeen    (araSeen),
    .addrHit    (addrHit),
    .statWrite  (statWrite),
    .faultEvent (faultEvent),
    .ctrl       (ctrl),
    .alertActive(alertActive),
    .araReplyReq(araReplyReq)
  );

  fault_alert_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .stuckPulse   (stuckPulse),
    .connFailPulse(connFailPulse),
    .chAlertN     (chAlertN),
    .chLive       (chLive),
    .chLatch      (chLatch),
    .stuckLatch   (stuckLatch),
    .connLatch    (connLatch),
    .faultEvent   (faultEvent)
  );

  assign alertN    = ~alertActive;
  assign statusReg = {alertActive, connLatch, stuckLatch, chLatch, chLive};
endmodule

// File: rtl/fault_alert_chk.sv
module fault_alert_chk #(
  parameter int NUM_CH = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                enable,
  input logic                stuckPulse,
  input logic                connFailPulse,
  input logic [NUM_CH-1:0]   chAlertN,
  input logic                araSeen,
  input logic                addrHit,
  input logic                statWrite,
  input logic                alertN,
  input logic [NUM_CH+3:0]   statusReg,
  input logic                araReplyReq
);
  localparam int CH_B = NUM_CH;
  localparam int ST_B = NUM_CH + 1;
  localparam int CF_B = NUM_CH + 2;
  localparam int AC_B = NUM_CH + 3;

  logic quiet;
  assign quiet = !stuckPulse && !connFailPulse &&
                 ((statusReg[NUM_CH-1:0] & ~chAlertN) == '0);

  a_r1_idle_after_disable: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> alertN && !araReplyReq && statusReg[AC_B:CH_B] == '0);

  a_r2_stuck_sets: assert property (@(posedge clk) disable iff (!rstN)
    enable && stuckPulse |=> statusReg[ST_B] && !alertN);

  a_r3_connfail_sets: assert property (@(posedge clk) disable iff (!rstN)
    enable && connFailPulse |=> statusReg[CF_B] && !alertN);

  a_r4_live_mirror: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> statusReg[NUM_CH-1:0] == $past(chAlertN));

  a_r5_ara_reply: assert property (@(posedge clk) disable iff (!rstN)
    enable && araSeen && !alertN |=> araReplyReq);

  a_r5_reply_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    araReplyReq |=> !araReplyReq);

  a_r6_no_reply_idle: assert property (@(posedge clk) disable iff (!rstN)
    alertN |=> !araReplyReq);

  a_r7_addr_release: assert property (@(posedge clk) disable iff (!rstN)
    enable && addrHit && quiet |=> alertN);

  a_r7_keep_sticky: assert property (@(posedge clk) disable iff (!rstN)
    enable && !statWrite && $past(enable) |=>
      (statusReg[CF_B:CH_B] & $past(statusReg[CF_B:CH_B])) == $past(statusReg[CF_B:CH_B]));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    enable && statWrite && quiet |=> alertN && statusReg[CF_B:CH_B] == '0);

  a_r11_alert_bit: assert property (@(posedge clk) disable iff (!rstN)
    statusReg[AC_B] == !alertN);
endmodule

bind fault_alert_unit fault_alert_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/fault_alert_unit_tb.sv
module fault_alert_unit_tb;
  localparam int NUM_CH = 4;
  localparam int SW = NUM_CH + 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b1;
  logic stuckPulse = 1'b0, connFailPulse = 1'b0;
  logic [NUM_CH-1:0] chAlertN = '1;
  logic araSeen = 1'b0, addrHit = 1'b0, statWrite = 1'b0;
  logic alertN;
  logic [SW-1:0] statusReg;
  logic araReplyReq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fault_alert_unit #(.NUM_CH(NUM_CH)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable),
    .stuckPulse(stuckPulse), .connFailPulse(connFailPulse),
    .chAlertN(chAlertN), .araSeen(araSeen), .addrHit(addrHit),
    .statWrite(statWrite), .alertN(alertN), .statusReg(statusReg),
    .araReplyReq(araReplyReq)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one edge passes; inputs were set 1 unit after the previous edge
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic dropStrobes();
    stuckPulse = 0; connFailPulse = 0; araSeen = 0; addrHit = 0; statWrite = 0;
  endtask

  function automatic logic [SW-1:0] expStat(input logic act, input logic cf,
      input logic st, input logic ch, input logic [NUM_CH-1:0] live);
    return {act, cf, st, ch, live};
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [NUM_CH-1:0] lowMask;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    tick();
    // R1 reset state
    chk("R1 reset alertN", 16'(alertN), 16'd1);
    chk("R1 reset status", 16'(statusReg), 16'h0F);
    chk("R1 reset reply", 16'(araReplyReq), 16'd0);

    // Sweep: every fault combination on every channel
    for (int ch = 0; ch < NUM_CH; ch++) begin
      for (int k = 1; k < 8; k++) begin
        logic eSt, eCf, eCh;
        eSt = k[0]; eCf = k[1]; eCh = k[2];
        lowMask = eCh ? NUM_CH'(1 << ch) : '0;
        stuckPulse = eSt; connFailPulse = eCf; chAlertN = ~lowMask;
        tick();
        dropStrobes();
        chk($sformatf("R2 R3 R4 R11 fault ch%0d k%0d status", ch, k), 16'(statusReg),
            16'(expStat(1'b1, eCf, eSt, eCh, ~lowMask)));
        chk($sformatf("R2 R3 R4 fault ch%0d k%0d alertN", ch, k), 16'(alertN), 16'd0);
        // clear with the channel still held low
        statWrite = 1;
        tick();
        dropStrobes();
        chk($sformatf("R9 R10 clear ch%0d k%0d", ch, k), 16'(statusReg),
            16'(expStat(1'b0, 1'b0, 1'b0, 1'b0, ~lowMask)));
        tick();
        chk($sformatf("R10 held low no relatch ch%0d k%0d", ch, k), 16'(alertN), 16'd1);
        chAlertN = '1;
        tick();
        chk($sformatf("R4 rise no fault ch%0d k%0d", ch, k), 16'(statusReg), 16'h0F);
      end
    end

    // R5 response address while asserted
    stuckPulse = 1; tick(); dropStrobes();
    araSeen = 1; tick(); dropStrobes();
    chk("R5 reply raised", 16'(araReplyReq), 16'd1);
    chk("R5 alert released", 16'(alertN), 16'd1);
    chk("R5 sticky kept", 16'(statusReg), 16'h2F);
    tick();
    chk("R5 reply one cycle", 16'(araReplyReq), 16'd0);
    // R6 response address while released
    araSeen = 1; tick(); dropStrobes();
    chk("R6 no reply", 16'(araReplyReq), 16'd0);
    // R8 new fault reasserts
    connFailPulse = 1; tick(); dropStrobes();
    chk("R8 reassert", 16'(statusReg), 16'hEF);
    // R7 direct addressing releases, keeps sticky bits
    addrHit = 1; tick(); dropStrobes();
    chk("R7 release", 16'(alertN), 16'd1);
    chk("R7 sticky kept", 16'(statusReg), 16'h6F);
    // R8 fault same cycle as release wins
    addrHit = 1; chAlertN = 4'b0111; tick(); dropStrobes();
    chk("R8 fault beats release", 16'(statusReg), 16'hF7);
    chAlertN = '1;
    // R9 clear with a simultaneous stuck pulse
    statWrite = 1; stuckPulse = 1; tick(); dropStrobes();
    chk("R9 clear vs new fault", 16'(statusReg), 16'hAF);
    statWrite = 1; tick(); dropStrobes();
    chk("R9 clear final", 16'(statusReg), 16'h0F);

    // R12 / R1 enable low
    connFailPulse = 1; tick(); dropStrobes();
    enable = 0; tick();
    chk("R1 disable releases", 16'(alertN), 16'd1);
    chk("R1 disable status", 16'(statusReg), 16'h0F);
    stuckPulse = 1; connFailPulse = 1; chAlertN = 4'b0000; araSeen = 1; tick();
    dropStrobes();
    chk("R12 ignored status", 16'(statusReg), 16'h0F);
    chk("R12 ignored reply", 16'(araReplyReq), 16'd0);
    chAlertN = '1; tick();
    enable = 1; tick();
    chk("R12 re-enable clean", 16'(statusReg), 16'h0F);
    chk("R12 re-enable alertN", 16'(alertN), 16'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule